// File: doc/BRIEF.md
# Redial Digit Store with Notepad Capture

This block keeps the most recently dialled telephone number, up to 23 key codes, so that it can be replayed on request. It holds two digit banks. One bank holds the main number. The other receives a notepad number typed during a conversation. Committing the notepad swaps the bank roles, so no digits are copied. Three counters manage the store: a main write count, a temporary write count and a read pointer. The read pointer always starts a replay from the first digit of the current main number.

A controlling dialler writes accepted key codes, starts a new number when the user goes off hook, and toggles notepad capture with the program key. It raises a replay request to redial. The block then presents the digits one at a time under a valid/ready handshake and pulses `done_o` after the last one. A flash event aborts any replay and rewinds the read pointer.

Standby behaves differently from a supply drop. Standby (`standby_i` high) returns the control machine to idle and keeps all digits and counters. A supply drop pulse (`brownout_i`) sets a sticky inhibit: every replay then finishes at once with no digits, until a new number is started or a notepad number is committed.

The control machine has four states:
- `ST_IDLE`: accepts digits into the main bank, new-number starts and replay requests.
  - Moves to `ST_NOTE` on the program key.
  - On a replay request, moves to `ST_PLAY`, or to `ST_DONE` when inhibited.
- `ST_NOTE`: captures digits into the temporary bank. A second program key commits the notepad number and moves back to `ST_IDLE`.
- `ST_PLAY`: offers digits. It moves to `ST_DONE` once the read pointer reaches the main count.
- `ST_DONE`: lasts one cycle with `done_o` high, then moves to `ST_IDLE`.

Standby and flash force `ST_IDLE` from any state.

Top module: `redial_store`

## Requirements
- R1: After reset `empty_o`=1, `full_o`=0, `dig_valid_o`=0 and `done_o`=0.
- R2: A replay presents the main number's digits in entry order. One digit advances per cycle with `dig_valid_o` and `dig_ready_i` both high, and `dig_o` holds while ready is low. The cycle after the last digit is consumed has valid low, and the cycle after that has `done_o` high for exactly one cycle.
- R3: The store holds at most 23 digits per bank. A write to a bank already holding 23 is dropped. `full_o` is high when the bank being written (the main bank in `ST_IDLE`, the temporary bank in `ST_NOTE`) holds 23.
- R4: Key codes are 4 bits: 0 to 9 are numerals, 10 to 13 are the letters A to D, 14 is star and 15 is hash. With `pulse_mode_i`=1, codes 10 to 15 are not stored.
- R5: `new_num_i` in `ST_IDLE` empties the main number (`empty_o`=1 next cycle) and clears the replay inhibit.
- R6: In `ST_IDLE`, `prog_i` starts notepad capture with an empty temporary bank. Digits written during capture leave the main number untouched. A second `prog_i` makes the captured digits the main number and clears the replay inhibit.
- R7: `flash_i` ends any replay (`dig_valid_o`=0 next cycle), abandons capture and rewinds the read pointer. The next replay starts from the first digit.
- R8: While `standby_i` is high, writes, new-number, program, flash and replay inputs have no effect. The state returns to `ST_IDLE` and the stored digits and counts are kept.
- R9: After a `brownout_i` pulse, a replay request produces `done_o` without any valid digit, until R5 or R6 clears the inhibit.
- R10: Replay requests outside `ST_IDLE` are ignored, and digit writes during `ST_PLAY` or `ST_DONE` are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; clears digits count and inhibit |
| standby_i | input | 1 | Standby; keeps contents and counters, returns control to idle |
| brownout_i | input | 1 | Supply-drop pulse; sets the sticky replay inhibit |
| pulse_mode_i | input | 1 | Pulse dialling mode; rejects non-numeric codes |
| wr_en_i | input | 1 | Digit write strobe |
| wr_digit_i | input | 4 | Key code to store |
| new_num_i | input | 1 | Start of a new main number |
| prog_i | input | 1 | Program key: begin or commit notepad capture |
| replay_req_i | input | 1 | Redial request |
| flash_i | input | 1 | Flash event |
| dig_ready_i | input | 1 | Consumer accepts the offered digit |
| dig_o | output | 4 | Replayed key code |
| dig_valid_o | output | 1 | `dig_o` holds a digit to consume |
| done_o | output | 1 | One-cycle pulse at the end of a replay |
| empty_o | output | 1 | Main number holds no digits |
| full_o | output | 1 | Bank being written holds 23 digits |

## Verification
The assertions take the control inputs to be single-cycle pulses that arrive one at a time. They also assume the consumer keeps `dig_ready_i` meaningful only while a digit is offered. The handshake-hold and flash-abort properties exclude the cycles where standby or flash themselves end the replay. The stimulus drives each command on its own cycle, mostly from a seeded random choice among writes, new numbers, program, flash, supply drops, standby and replays with random ready gaps. During replays it asserts writes only after the request has been taken. Directed sequences add the overflow, pulse-mode rejection, mid-replay flash and standby, and inhibit corners.

// File: rtl/redial_pkg.sv
package redial_pkg;
    localparam int DIG_W = 4;
    localparam int BANKS = 2;
    localparam logic [DIG_W-1:0] NUMERIC_MAX = 4'd9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NOTE,
        ST_PLAY,
        ST_DONE
    } store_state_e;
endpackage

// File: rtl/redial_bank.sv
module redial_bank
    import redial_pkg::*;
#(
    parameter int DEPTH  = 23,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DIG_W-1:0]  wdata,
    input  logic              rbank,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DIG_W-1:0]  rdata
);
    logic [DIG_W-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DIG_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) begin
                cells[waddr] <= wdata;
            end
        end

        assign bank_rd[b] = cells[raddr];
    end

    assign rdata = bank_rd[rbank];
endmodule

// File: rtl/redial_ptrs.sv
module redial_ptrs #(
    parameter int DEPTH  = 23,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_main,
    input  logic              wr_tmp,
    input  logic              num_clear,
    input  logic              note_begin,
    input  logic              note_commit,
    input  logic              rd_rewind,
    input  logic              rd_step,
    input  logic              brownout,
    output logic              main_full,
    output logic              tmp_full,
    output logic              main_empty,
    output logic              rd_at_end,
    output logic              inhibit,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_bank,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] main_cnt_q;
    logic [CNT_W-1:0] tmp_cnt_q;
    logic [CNT_W-1:0] rd_ptr_q;
    logic             main_sel_q;
    logic             inhibit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_cnt_q <= '0;
            tmp_cnt_q  <= '0;
            rd_ptr_q   <= '0;
            main_sel_q <= 1'b0;
            inhibit_q  <= 1'b0;
        end else begin
            if (num_clear) begin
                main_cnt_q <= '0;
            end else if (note_commit) begin
                main_cnt_q <= tmp_cnt_q;
            end else if (wr_main) begin
                main_cnt_q <= main_cnt_q + 1'b1;
            end

            if (note_begin) begin
                tmp_cnt_q <= '0;
            end else if (wr_tmp) begin
                tmp_cnt_q <= tmp_cnt_q + 1'b1;
            end

            if (note_commit) begin
                main_sel_q <= ~main_sel_q;
            end

            if (rd_rewind) begin
                rd_ptr_q <= '0;
            end else if (rd_step) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end

            if (brownout) begin
                inhibit_q <= 1'b1;
            end else if (num_clear || note_commit) begin
                inhibit_q <= 1'b0;
            end
        end
    end

    assign main_full  = (main_cnt_q == CNT_MAX);
    assign tmp_full   = (tmp_cnt_q == CNT_MAX);
    assign main_empty = (main_cnt_q == '0);
    assign rd_at_end  = (rd_ptr_q == main_cnt_q);
    assign inhibit    = inhibit_q;
    assign wr_bank    = wr_tmp ? ~main_sel_q : main_sel_q;
    assign wr_addr    = wr_tmp ? tmp_cnt_q[ADDR_W-1:0] : main_cnt_q[ADDR_W-1:0];
    assign rd_bank    = main_sel_q;
    assign rd_addr    = rd_ptr_q[ADDR_W-1:0];

    // R3: neither bank count ever passes the capacity
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_cnt_q <= CNT_MAX) && (tmp_cnt_q <= CNT_MAX));

    // R2: replay never reads past the end of the main number
    p_rd_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_q <= main_cnt_q);

    // R3: a count at capacity does not grow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_full && !num_clear && !note_commit) |=> main_full);
endmodule

// File: rtl/redial_ctrl.sv
module redial_ctrl
    import redial_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             flash_i,
    input  logic             new_num_i,
    input  logic             prog_i,
    input  logic             replay_req_i,
    input  logic             wr_en_i,
    input  logic [DIG_W-1:0] wr_digit_i,
    input  logic             pulse_mode_i,
    input  logic             dig_ready_i,
    input  logic             main_full,
    input  logic             tmp_full,
    input  logic             rd_at_end,
    input  logic             inhibit,
    input  logic [DIG_W-1:0] dig_i,
    output store_state_e     state_o,
    output logic             wr_main,
    output logic             wr_tmp,
    output logic             num_clear,
    output logic             note_begin,
    output logic             note_commit,
    output logic             rd_rewind,
    output logic             rd_step,
    output logic             dig_valid_o,
    output logic             done_o
);
    store_state_e state_q;
    store_state_e state_d;

    logic keys_ok;
    logic digit_ok;

    assign keys_ok  = !standby_i && !flash_i;
    assign digit_ok = wr_en_i && keys_ok && !new_num_i && !prog_i
                      && !(pulse_mode_i && (wr_digit_i > NUMERIC_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!keys_ok) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (prog_i) begin
                        state_d = ST_NOTE;
                    end else if (replay_req_i) begin
                        state_d = inhibit ? ST_DONE : ST_PLAY;
                    end
                end
                ST_NOTE: begin
                    if (prog_i) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_PLAY: begin
                    if (rd_at_end) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_main     = 1'b0;
        wr_tmp      = 1'b0;
        num_clear   = 1'b0;
        note_begin  = 1'b0;
        note_commit = 1'b0;
        rd_rewind   = 1'b0;
        dig_valid_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_main    = digit_ok && !main_full;
                num_clear  = keys_ok && new_num_i && !prog_i;
                note_begin = keys_ok && prog_i;
                rd_rewind  = keys_ok && (replay_req_i || new_num_i) && !prog_i;
            end
            ST_NOTE: begin
                wr_tmp      = digit_ok && !tmp_full;
                note_commit = keys_ok && prog_i;
                rd_rewind   = keys_ok && prog_i;
            end
            ST_PLAY: begin
                dig_valid_o = !rd_at_end;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
        endcase
        if (flash_i && !standby_i) begin
            rd_rewind = 1'b1;
        end
    end

    assign rd_step = dig_valid_o && dig_ready_i && keys_ok;
    assign state_o = state_q;

    // R2: end of replay is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: an offered digit stays offered and unchanged until taken
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid_o && !dig_ready_i && keys_ok) |=> (dig_valid_o && $stable(dig_i)));

    // R7: flash ends any replay
    p_flash_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_i && !standby_i) |=> (!dig_valid_o && !done_o));

    // R8: standby leaves the handshake quiet
    p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!dig_valid_o && !done_o));

    // R9: an inhibited request offers no digit
    p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && replay_req_i && inhibit && keys_ok) |=> !dig_valid_o);

    // R10: replay request during capture is ignored
    p_note_no_play_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOTE && replay_req_i) |=> !dig_valid_o);
endmodule

// File: rtl/redial_store.sv
module redial_store
    import redial_pkg::*;
#(
    parameter int DEPTH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             brownout_i,
    input  logic             pulse_mode_i,
    input  logic             wr_en_i,
    input  logic [DIG_W-1:0] wr_digit_i,
    input  logic             new_num_i,
    input  logic             prog_i,
    input  logic             replay_req_i,
    input  logic             flash_i,
    input  logic             dig_ready_i,
    output logic [DIG_W-1:0] dig_o,
    output logic             dig_valid_o,
    output logic             done_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = $clog2(DEPTH);

    store_state_e      state;
    logic              wr_main, wr_tmp, num_clear, note_begin, note_commit;
    logic              rd_rewind, rd_step;
    logic              main_full, tmp_full, main_empty, rd_at_end, inhibit;
    logic              wr_bank, rd_bank;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    redial_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .flash_i      (flash_i),
        .new_num_i    (new_num_i),
        .prog_i       (prog_i),
        .replay_req_i (replay_req_i),
        .wr_en_i      (wr_en_i),
        .wr_digit_i   (wr_digit_i),
        .pulse_mode_i (pulse_mode_i),
        .dig_ready_i  (dig_ready_i),
        .main_full    (main_full),
        .tmp_full     (tmp_full),
        .rd_at_end    (rd_at_end),
        .inhibit      (inhibit),
        .dig_i        (dig_o),
        .state_o      (state),
        .wr_main      (wr_main),
        .wr_tmp       (wr_tmp),
        .num_clear    (num_clear),
        .note_begin   (note_begin),
        .note_commit  (note_commit),
        .rd_rewind    (rd_rewind),
        .rd_step      (rd_step),
        .dig_valid_o  (dig_valid_o),
        .done_o       (done_o)
    );

    redial_ptrs #(
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_main     (wr_main),
        .wr_tmp      (wr_tmp),
        .num_clear   (num_clear),
        .note_begin  (note_begin),
        .note_commit (note_commit),
        .rd_rewind   (rd_rewind),
        .rd_step     (rd_step),
        .brownout    (brownout_i),
        .main_full   (main_full),
        .tmp_full    (tmp_full),
        .main_empty  (main_empty),
        .rd_at_end   (rd_at_end),
        .inhibit     (inhibit),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .rd_bank     (rd_bank),
        .rd_addr     (rd_addr)
    );

    redial_bank #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk   (clk),
        .we    (wr_main || wr_tmp),
        .wbank (wr_bank),
        .waddr (wr_addr),
        .wdata (wr_digit_i),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (dig_o)
    );

    assign empty_o = main_empty;
    assign full_o  = (state == ST_NOTE) ? tmp_full : main_full;

    // R4: a rejected pulse-mode key changes neither empty nor full
    p_pulse_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && pulse_mode_i && (wr_digit_i > NUMERIC_MAX) && !new_num_i && !prog_i
         && !flash_i && !standby_i && !replay_req_i)
        |=> ($stable(empty_o) && $stable(full_o)));

    // R5: a new number empties the main store
    p_new_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && new_num_i && !prog_i && !standby_i && !flash_i) |=> empty_o);

    // R8: standby keeps the main count
    p_standby_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> $stable(empty_o));
endmodule

// File: tb/redial_store_tb.sv
module redial_store_tb;
    localparam int DEPTH = 23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0, brownout_i = 1'b0, pulse_mode_i = 1'b0;
    logic       wr_en_i = 1'b0, new_num_i = 1'b0, prog_i = 1'b0;
    logic       replay_req_i = 1'b0, flash_i = 1'b0, dig_ready_i = 1'b0;
    logic [3:0] wr_digit_i = 4'd0;
    logic [3:0] dig_o;
    logic       dig_valid_o, done_o, empty_o, full_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    int m_dig [DEPTH];
    int t_dig [DEPTH];
    int m_cnt = 0, t_cnt = 0;
    bit in_note = 1'b0, inhib = 1'b0;

    always #5 clk = ~clk;

    redial_store #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .brownout_i(brownout_i),
        .pulse_mode_i(pulse_mode_i), .wr_en_i(wr_en_i), .wr_digit_i(wr_digit_i),
        .new_num_i(new_num_i), .prog_i(prog_i), .replay_req_i(replay_req_i),
        .flash_i(flash_i), .dig_ready_i(dig_ready_i), .dig_o(dig_o),
        .dig_valid_o(dig_valid_o), .done_o(done_o), .empty_o(empty_o), .full_o(full_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_full();
        return in_note ? int'(t_cnt == DEPTH) : int'(m_cnt == DEPTH);
    endfunction

    function automatic bit accepts(int d);
        return !(pulse_mode_i && d > 9);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check_flags(string req);
        check({req, " empty"}, int'(empty_o), int'(m_cnt == 0));
        check({req, " full"}, int'(full_o), exp_full());
    endtask

    task automatic op_write(int d);
        @(negedge clk); wr_en_i = 1'b1; wr_digit_i = 4'(d);
        @(negedge clk); wr_en_i = 1'b0;
        if (accepts(d)) begin
            if (in_note) begin
                if (t_cnt < DEPTH) begin t_dig[t_cnt] = d; t_cnt++; end
            end else if (m_cnt < DEPTH) begin
                m_dig[m_cnt] = d; m_cnt++;
            end
        end
        check_flags("R3/R4 write");
    endtask

    task automatic op_new();
        @(negedge clk); new_num_i = 1'b1;
        @(negedge clk); new_num_i = 1'b0;
        if (!in_note) begin m_cnt = 0; inhib = 1'b0; end
        check_flags("R5 new");
    endtask

    task automatic op_prog();
        @(negedge clk); prog_i = 1'b1;
        @(negedge clk); prog_i = 1'b0;
        if (!in_note) begin
            in_note = 1'b1; t_cnt = 0;
        end else begin
            in_note = 1'b0;
            for (int i = 0; i < t_cnt; i++) m_dig[i] = t_dig[i];
            m_cnt = t_cnt; inhib = 1'b0;
        end
        check_flags("R6 prog");
    endtask

    task automatic op_flash();
        @(negedge clk); flash_i = 1'b1;
        @(negedge clk); flash_i = 1'b0;
        in_note = 1'b0;
        check_flags("R7 flash");
    endtask

    task automatic op_brownout();
        @(negedge clk); brownout_i = 1'b1;
        @(negedge clk); brownout_i = 1'b0;
        inhib = 1'b1;
    endtask

    task automatic op_standby();
        @(negedge clk);
        standby_i = 1'b1; wr_en_i = 1'b1; wr_digit_i = 4'd7;
        new_num_i = 1'b1; replay_req_i = 1'b1;
        @(negedge clk);
        standby_i = 1'b0; wr_en_i = 1'b0; new_num_i = 1'b0; replay_req_i = 1'b0;
        in_note = 1'b0;
        check("R8 standby valid", int'(dig_valid_o), 0);
        check_flags("R8 standby");
    endtask

    // full replay with random ready gaps; optional writes during play (R10)
    task automatic op_replay(string req, bit noisy);
        int n = inhib ? 0 : m_cnt;
        int idx = 0;
        bit got_done = 1'b0;
        @(negedge clk); replay_req_i = 1'b1;
        @(negedge clk); replay_req_i = 1'b0;
        for (int c = 0; c < 400 && !got_done; c++) begin
            if (done_o) begin
                got_done = 1'b1;
                wr_en_i = 1'b0;
            end else begin
                if (dig_valid_o) begin
                    if (idx < n) check({req, " R2 digit"}, int'(dig_o), m_dig[idx]);
                    else check({req, " R9 extra digit"}, idx, n);
                    dig_ready_i = 1'($urandom_range(0, 1));
                    if (dig_ready_i) idx++;
                end else begin
                    dig_ready_i = 1'b0;
                end
                if (noisy) begin wr_en_i = 1'b1; wr_digit_i = 4'($urandom_range(0, 9)); end
                @(negedge clk);
            end
        end
        dig_ready_i = 1'b0; wr_en_i = 1'b0;
        check({req, " R2 done seen"}, int'(got_done), 1);
        check({req, " R2 count"}, idx, n);
        @(negedge clk);
        check({req, " R2 done single"}, int'(done_o), 0);
        check_flags({req, " R10 after"});
    endtask

    // partial replay interrupted by flash (mode 0) or standby (mode 1)
    task automatic op_interrupt(int k, bit use_standby);
        @(negedge clk); replay_req_i = 1'b1;
        @(negedge clk); replay_req_i = 1'b0;
        for (int i = 0; i < k; i++) begin
            check("R2 partial digit", int'(dig_o), m_dig[i]);
            dig_ready_i = 1'b1;
            @(negedge clk);
        end
        dig_ready_i = 1'b0;
        if (use_standby) op_standby();
        else begin
            @(negedge clk); flash_i = 1'b1;
            @(negedge clk); flash_i = 1'b0;
            check("R7 flash ends replay", int'(dig_valid_o), 0);
            check("R7 no done", int'(done_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty", int'(empty_o), 1);
        check("R1 full", int'(full_o), 0);
        check("R1 valid", int'(dig_valid_o), 0);
        check("R1 done", int'(done_o), 0);

        // R2: basic replay
        op_new();
        for (int d = 1; d <= 6; d++) op_write(d);
        op_replay("R2 basic", 1'b0);

        // R3: overflow
        op_new();
        for (int i = 0; i < DEPTH + 3; i++) op_write((i * 7) % 16);
        check("R3 full raised", int'(full_o), 1);
        op_replay("R3 full replay", 1'b0);

        // R4: pulse-mode rejection
        pulse_mode_i = 1'b1;
        op_new();
        for (int d = 10; d < 16; d++) op_write(d);
        check("R4 still empty", int'(empty_o), 1);
        op_write(3);
        op_write(14);
        op_write(9);
        op_replay("R4 replay", 1'b0);
        pulse_mode_i = 1'b0;

        // R7: flash mid-replay, then full replay from start
        op_new();
        for (int d = 0; d < 8; d++) op_write(15 - d);
        op_interrupt(3, 1'b0);
        op_replay("R7 rewind", 1'b0);

        // R8: standby mid-replay keeps contents
        op_interrupt(2, 1'b1);
        op_replay("R8 kept", 1'b0);

        // R10: writes during replay and replay during capture ignored
        op_replay("R10 noisy", 1'b1);
        op_replay("R10 recheck", 1'b0);
        op_prog();
        @(negedge clk); replay_req_i = 1'b1;
        @(negedge clk); replay_req_i = 1'b0;
        check("R10 note ignores replay", int'(dig_valid_o), 0);
        // R6: capture leaves main intact, commit swaps
        op_write(4); op_write(2);
        op_flash();
        op_replay("R6 main intact", 1'b0);
        op_prog();
        op_write(11); op_write(5); op_write(0);
        op_prog();
        op_replay("R6 committed", 1'b0);

        // R9: inhibit, then cleared by new number
        op_brownout();
        op_replay("R9 inhibited", 1'b0);
        op_new();
        op_write(8);
        op_replay("R9 cleared", 1'b0);

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int sel = $urandom_range(0, 99);
            if (sel < 50) op_write($urandom_range(0, 15));
            else if (sel < 56) op_new();
            else if (sel < 62) op_prog();
            else if (sel < 66) op_flash();
            else if (sel < 68) op_brownout();
            else if (sel < 72) op_standby();
            else if (sel < 80) begin
                @(negedge clk); pulse_mode_i = 1'($urandom_range(0, 1));
            end else if (!in_note) op_replay("R2 random", 1'($urandom_range(0, 1)));
            else op_write($urandom_range(0, 15));
        end
        if (in_note) op_prog();
        op_replay("R2 final", 1'b0);
        finish_run();
    end
endmodule